// File: doc/BRIEF.md
# Current-Measurement Alert and Status Logic

This block watches the stream of current-channel conversion results from a power monitor and keeps the alert and status bits. Each time a result is presented, its upper eight bits are compared against a programmable threshold. An over-threshold result can raise a sticky alert at once, or only after a run of consecutive over-threshold results. Two hot-swap conditions can raise their own sticky alerts: the switch being held off by an overcurrent fault, and the switch being turned off by the enable pin or by software. A single alert output is the OR of the three sticky bits. A write of the enable register with its clear bit set wipes all sticky bits one cycle later, and that bit then drops back to zero.

Three small state machines do the work. The run tracker has states STK_IDLE, STK_RUN and STK_FULL. An over-threshold result moves STK_IDLE to STK_RUN, or to STK_FULL when the run length is one. STK_RUN advances its count and moves to STK_FULL when the count reaches the run length. STK_FULL holds on further over-threshold results. Any result at or under the threshold returns the tracker to STK_IDLE. The clear sequencer moves CLR_IDLE to CLR_FIRE on a write that has the clear bit set, and returns to CLR_IDLE on the next cycle unless another such write comes in. Each sticky alert cell moves LAT_EMPTY to LAT_HELD when its cause is enabled and present, and returns to LAT_EMPTY only in the CLR_FIRE cycle.

Top module: `mas_alert_status`

## Requirements
- R1: After reset the threshold is 0xFF, the enable register holds only bit 2 (fault alert enable), all three sticky bits are 0 and `alert` is 0. With the reset threshold, no result (not even 0xFFF) sets status bit 0.
- R2: Status bit 0 is set in the cycle after a valid result whose bits [11:4] are strictly greater than the threshold, and is cleared in the cycle after a valid result that is not. Without `res_valid` it keeps its value. A threshold write (`thr_wr`) loads `thr_wdata` at that clock edge.
- R3: When enable bit 0 is set and status bit 0 is 1, status bit 1 (sticky result alert) is set at the next clock edge.
- R4: When enable bit 1 is set, status bit 1 is set one edge after the fourth consecutive over-threshold result. A result that is not over the threshold restarts the count, and the count saturates at four.
- R5: Status bit 2 follows `hs_oc_off` directly. When enable bit 2 is set and `hs_oc_off` is 1 at a clock edge, status bit 3 (sticky fault alert) is set at that edge.
- R6: Status bit 4 is 1 whenever `en_pin` is 0 or `sw_off` is 1. When enable bit 3 is set and that condition holds at a clock edge, status bit 5 (sticky off alert) is set at that edge.
- R7: A sticky bit stays at 1 after its cause goes away or its enable is removed, until a clear.
- R8: A write of the enable register with bit 4 set clears all three sticky bits at the following edge, and bit 4 reads as 0 again after that edge. A sticky bit whose enabled cause is still present is set again one edge later.
- R9: `alert` is 1 exactly when at least one of status bits 1, 3 and 5 is 1.
- R10: A cause whose enable bit is 0 never sets its sticky bit. An enable write (`en_wr`) loads bits [3:0] of `en_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Strobe: a new current result is on `res_data` |
| res_data | input | 12 | Current conversion result |
| hs_oc_off | input | 1 | Hot-swap is latched off or cooling down after an overcurrent fault |
| en_pin | input | 1 | Hot-swap enable pin level, active high |
| sw_off | input | 1 | Software-off control bit |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 5 | Enable write data: [0] single, [1] run, [2] fault, [3] off, [4] clear |
| thr_wr | input | 1 | Write strobe for the threshold register |
| thr_wdata | input | 8 | Threshold write data |
| status | output | 6 | {off alert, off state, fault alert, fault live, result alert, result over} |
| alert | output | 1 | OR of the three sticky alert bits |

## Verification
The hardest situation to reach is a run-mode trip that depends on exact ordering. Three over-threshold results, then one result exactly at the threshold, then more over-threshold results must trip only on the fourth result after the break. The result at the threshold must count as "not over". Directed sequences build these runs around the boundary value threshold·16+15. Random traffic biases results to within a few codes of the threshold, so runs start and break often. A clear written while a run is still saturated shows the sticky bit coming back one edge after it was wiped.

// File: rtl/mas_pkg.sv
package mas_pkg;

    // Status byte positions (decoded by the bus side)
    localparam int ST_ADC_LIVE = 0;
    localparam int ST_ADC_LAT  = 1;
    localparam int ST_HS_LIVE  = 2;
    localparam int ST_HS_LAT   = 3;
    localparam int ST_OFF_LIVE = 4;
    localparam int ST_OFF_LAT  = 5;
    localparam int ST_W        = 6;

    // Enable register positions
    localparam int EN_SINGLE = 0;
    localparam int EN_RUN    = 1;
    localparam int EN_FAULT  = 2;
    localparam int EN_OFF    = 3;
    localparam int EN_CLEAR  = 4;

    // Sticky alert cell indices
    localparam int LAT_N   = 3;
    localparam int L_ADC   = 0;
    localparam int L_FAULT = 1;
    localparam int L_OFF   = 2;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_RUN  = 2'd1,
        STK_FULL = 2'd2
    } stk_state_e;

    typedef enum logic {
        CLR_IDLE = 1'b0,
        CLR_FIRE = 1'b1
    } clr_state_e;

    typedef enum logic {
        LAT_EMPTY = 1'b0,
        LAT_HELD  = 1'b1
    } lat_state_e;

endpackage

// File: rtl/mas_ctrl.sv
module mas_ctrl
    import mas_pkg::*;
#(
    parameter int ENA_W   = 5,
    parameter int THR_W   = 8,
    parameter logic [ENA_W-2:0] ENA_RST = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [ENA_W-1:0]   en_wdata,
    input  logic               thr_wr,
    input  logic [THR_W-1:0]   thr_wdata,
    output logic [ENA_W-2:0]   ena,
    output logic [THR_W-1:0]   thr,
    output logic               clr_pulse
);

    localparam logic [THR_W-1:0] THR_RST = '1;

    clr_state_e clr_q, clr_d;
    logic       clr_req;

    assign clr_req = en_wr && en_wdata[EN_CLEAR];

    // Enable and threshold registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena <= ENA_RST;
            thr <= THR_RST;
        end else begin
            if (en_wr)  ena <= en_wdata[ENA_W-2:0];
            if (thr_wr) thr <= thr_wdata;
        end
    end

    // Clear sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= CLR_IDLE;
        else        clr_q <= clr_d;
    end

    // Clear sequencer: next state
    always_comb begin
        clr_d = clr_q;
        unique case (clr_q)
            CLR_IDLE: if (clr_req) clr_d = CLR_FIRE;
            CLR_FIRE: if (!clr_req) clr_d = CLR_IDLE;
            default:  clr_d = CLR_IDLE;
        endcase
    end

    // Clear sequencer: outputs
    always_comb begin
        clr_pulse = 1'b0;
        unique case (clr_q)
            CLR_IDLE: clr_pulse = 1'b0;
            CLR_FIRE: clr_pulse = 1'b1;
            default:  clr_pulse = 1'b0;
        endcase
    end

    // R8
    clear_self_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !clr_req) |=> !clr_pulse);

    // R2
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_wr |=> $stable(thr));

endmodule

// File: rtl/mas_streak.sv
module mas_streak
    import mas_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int THR_W   = 8,
    parameter int RUN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [THR_W-1:0]  thr,
    output logic              live_over,
    output logic              run_full
);

    localparam int SHIFT = DATA_W - THR_W;
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_LEN);

    stk_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W:0]   bound;
    logic              over;

    // Upper THR_W bits strictly above thr <=> data >= (thr+1) << SHIFT
    assign bound = {({1'b0, thr} + (THR_W+1)'(1)), {SHIFT{1'b0}}};
    assign over  = ({1'b0, res_data} >= bound);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= STK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (res_valid) begin
            if (!over) begin
                st_d  = STK_IDLE;
                cnt_d = '0;
            end else begin
                unique case (st_q)
                    STK_IDLE: begin
                        cnt_d = CNT_ONE;
                        st_d  = (CNT_ONE == CNT_TOP) ? STK_FULL : STK_RUN;
                    end
                    STK_RUN: begin
                        cnt_d = cnt_q + CNT_ONE;
                        st_d  = (cnt_q + CNT_ONE == CNT_TOP) ? STK_FULL : STK_RUN;
                    end
                    STK_FULL: begin
                        cnt_d = CNT_TOP;
                        st_d  = STK_FULL;
                    end
                    default: begin
                        cnt_d = '0;
                        st_d  = STK_IDLE;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        live_over = 1'b0;
        run_full  = 1'b0;
        unique case (st_q)
            STK_IDLE: begin live_over = 1'b0; run_full = 1'b0; end
            STK_RUN:  begin live_over = 1'b1; run_full = 1'b0; end
            STK_FULL: begin live_over = 1'b1; run_full = 1'b1; end
            default:  begin live_over = 1'b0; run_full = 1'b0; end
        endcase
    end

    // R2
    under_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !over) |=> (!live_over && !run_full));

    // R2
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(st_q));

    // R4
    run_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_full && res_valid && over) |=> run_full);

    // R4
    full_needs_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_full) |-> $past(res_valid && over));

endmodule

// File: rtl/mas_latch.sv
module mas_latch
    import mas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    lat_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LAT_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LAT_EMPTY: if (!clr && set) st_d = LAT_HELD;
            LAT_HELD:  if (clr)         st_d = LAT_EMPTY;
            default:   st_d = LAT_EMPTY;
        endcase
    end

    always_comb begin
        q = 1'b0;
        unique case (st_q)
            LAT_EMPTY: q = 1'b0;
            LAT_HELD:  q = 1'b1;
            default:   q = 1'b0;
        endcase
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);

    // R8
    clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);

    // R10
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(set));

endmodule

// File: rtl/mas_alert_status.sv
module mas_alert_status
    import mas_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int THR_W   = 8,
    parameter int RUN_LEN = 4,
    parameter int ENA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              hs_oc_off,
    input  logic              en_pin,
    input  logic              sw_off,
    input  logic              en_wr,
    input  logic [ENA_W-1:0]  en_wdata,
    input  logic              thr_wr,
    input  logic [THR_W-1:0]  thr_wdata,
    output logic [ST_W-1:0]   status,
    output logic              alert
);

    logic [ENA_W-2:0] ena;
    logic [THR_W-1:0] thr;
    logic             clr_pulse;
    logic             live_over;
    logic             run_full;
    logic             off_live;
    logic [LAT_N-1:0] lat_set;
    logic [LAT_N-1:0] lat_q;

    mas_ctrl #(
        .ENA_W (ENA_W),
        .THR_W (THR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .thr_wr    (thr_wr),
        .thr_wdata (thr_wdata),
        .ena       (ena),
        .thr       (thr),
        .clr_pulse (clr_pulse)
    );

    mas_streak #(
        .DATA_W  (DATA_W),
        .THR_W   (THR_W),
        .RUN_LEN (RUN_LEN)
    ) u_streak (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .thr       (thr),
        .live_over (live_over),
        .run_full  (run_full)
    );

    assign off_live = !en_pin || sw_off;

    always_comb begin
        lat_set          = '0;
        lat_set[L_ADC]   = (ena[EN_SINGLE] && live_over) || (ena[EN_RUN] && run_full);
        lat_set[L_FAULT] = ena[EN_FAULT] && hs_oc_off;
        lat_set[L_OFF]   = ena[EN_OFF] && off_live;
    end

    for (genvar g = 0; g < LAT_N; g++) begin : g_lat
        mas_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (lat_set[g]),
            .clr   (clr_pulse),
            .q     (lat_q[g])
        );
    end

    always_comb begin
        status              = '0;
        status[ST_ADC_LIVE] = live_over;
        status[ST_ADC_LAT]  = lat_q[L_ADC];
        status[ST_HS_LIVE]  = hs_oc_off;
        status[ST_HS_LAT]   = lat_q[L_FAULT];
        status[ST_OFF_LIVE] = off_live;
        status[ST_OFF_LAT]  = lat_q[L_OFF];
    end

    assign alert = |lat_q;

    // R8
    clear_drops_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !alert);

    // R5
    fault_alert_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pulse && ena[EN_FAULT] && hs_oc_off) |=> status[ST_HS_LAT]);

    // R6
    off_alert_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pulse && ena[EN_OFF] && (!en_pin || sw_off)) |=> status[ST_OFF_LAT]);

endmodule

// File: tb/sim_mas_alert_status.sv
`timescale 1ns/1ps
module sim_mas_alert_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic        hs_oc_off = 1'b0;
    logic        en_pin = 1'b1;
    logic        sw_off = 1'b0;
    logic        en_wr = 1'b0;
    logic [4:0]  en_wdata = '0;
    logic        thr_wr = 1'b0;
    logic [7:0]  thr_wdata = '0;
    logic [5:0]  status;
    logic        alert;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    logic [7:0] m_thr;
    logic [3:0] m_en;
    logic       m_live;
    int         m_run;
    logic [2:0] m_lat;
    logic       m_clr;

    always #5 clk = ~clk;

    mas_alert_status u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .hs_oc_off(hs_oc_off), .en_pin(en_pin), .sw_off(sw_off),
        .en_wr(en_wr), .en_wdata(en_wdata), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
        .status(status), .alert(alert)
    );

    function automatic logic [5:0] exp_status();
        return {m_lat[2], (!en_pin || sw_off), m_lat[1], hs_oc_off, m_lat[0], m_live};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " status"}, {2'b00, status}, {2'b00, exp_status()});
        check({tag, " alert"}, {7'd0, alert}, {7'd0, |m_lat});
    endtask

    // One clock: model next state from current inputs, then compare at negedge
    task automatic step(input string tag);
        logic       over, live_n, clr_n;
        int         run_n;
        logic [2:0] set, lat_n;
        logic [3:0] en_n;
        logic [7:0] thr_n;
        over   = res_data[11:4] > m_thr;
        live_n = m_live;
        run_n  = m_run;
        if (res_valid) begin
            live_n = over;
            run_n  = over ? ((m_run >= 4) ? 4 : m_run + 1) : 0;
        end
        set[0] = (m_en[0] && m_live) || (m_en[1] && (m_run >= 4));
        set[1] = m_en[2] && hs_oc_off;
        set[2] = m_en[3] && (!en_pin || sw_off);
        lat_n  = m_clr ? 3'b000 : (m_lat | set);
        clr_n  = en_wr && en_wdata[4];
        en_n   = en_wr ? en_wdata[3:0] : m_en;
        thr_n  = thr_wr ? thr_wdata : m_thr;
        @(posedge clk);
        m_live = live_n; m_run = run_n; m_lat = lat_n;
        m_clr = clr_n; m_en = en_n; m_thr = thr_n;
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic idle(input string tag);
        res_valid = 0; en_wr = 0; thr_wr = 0;
        step(tag);
    endtask

    task automatic convert(input logic [11:0] d, input string tag);
        res_valid = 1; res_data = d;
        step(tag);
        res_valid = 0;
    endtask

    task automatic write_en(input logic [4:0] v, input string tag);
        en_wr = 1; en_wdata = v;
        step(tag);
        en_wr = 0;
    endtask

    task automatic write_thr(input logic [7:0] v, input string tag);
        thr_wr = 1; thr_wdata = v;
        step(tag);
        thr_wr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1175));
        m_thr = 8'hFF; m_en = 4'b0100; m_live = 0; m_run = 0; m_lat = 0; m_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1 reset");
        check("R1 status zero", {2'b00, status}, 8'h00);
        convert(12'hFFF, "R1 full-scale under reset thr");
        check("R1 no over at thr FF", {7'd0, status[0]}, 8'd0);

        // R2 compare boundary
        write_thr(8'h80, "R2 thr write");
        convert(12'h810, "R2 over");
        check("R2 bit0 set", {7'd0, status[0]}, 8'd1);
        idle("R2 hold");
        check("R2 bit0 held", {7'd0, status[0]}, 8'd1);
        check("R10 no latch while disabled", {7'd0, status[1]}, 8'd0);
        convert(12'h80F, "R2 equal not over");
        check("R2 bit0 clear at equal", {7'd0, status[0]}, 8'd0);

        // R3 single mode
        write_en(5'b00001, "R3 enable single");
        convert(12'h900, "R3 over");
        idle("R3 latch");
        check("R3 bit1 set", {7'd0, status[1]}, 8'd1);
        check("R9 alert", {7'd0, alert}, 8'd1);
        convert(12'h100, "R7 under");
        idle("R7 sticky");
        check("R7 bit1 sticky", {7'd0, status[1]}, 8'd1);

        // R8 clear with cause present
        convert(12'hA00, "R8 cause");
        write_en(5'b10001, "R8 clear write");
        idle("R8 clear edge");
        check("R8 bit1 wiped", {7'd0, status[1]}, 8'd0);
        idle("R8 reassert");
        check("R8 bit1 back", {7'd0, status[1]}, 8'd1);
        convert(12'h000, "R8 cause gone");
        write_en(5'b10000, "R8 clear and disable");
        idle("R8 clear edge 2");
        idle("R8 stays clear");
        check("R8 bit1 stays 0", {7'd0, status[1]}, 8'd0);

        // R4 run mode with a break exactly at the threshold
        write_en(5'b00010, "R4 enable run");
        for (int i = 0; i < 3; i++) convert(12'h8A0, "R4 run a");
        convert(12'h80F, "R4 break");
        for (int i = 0; i < 3; i++) convert(12'h8A0, "R4 run b");
        idle("R4 three only");
        check("R4 no trip at three", {7'd0, status[1]}, 8'd0);
        convert(12'h8A0, "R4 fourth");
        idle("R4 trip");
        check("R4 bit1 after four", {7'd0, status[1]}, 8'd1);
        for (int i = 0; i < 3; i++) convert(12'hFFF, "R4 saturate");
        write_en(5'b10010, "R4 clear while full");
        idle("R4 wipe");
        idle("R4 reassert");
        check("R4 saturated run reasserts", {7'd0, status[1]}, 8'd1);

        // R5 fault alert
        write_en(5'b10100, "R5 clear, enable fault");
        idle("R5 wipe");
        hs_oc_off = 1;
        idle("R5 set");
        check("R5 live and latch", {6'd0, status[3:2]}, 8'd3);
        hs_oc_off = 0;
        idle("R7 fault sticky");
        check("R7 fault latch held", {6'd0, status[3:2]}, 8'd2);

        // R6 off alert via pin then software
        write_en(5'b11000, "R6 clear, enable off");
        idle("R6 wipe");
        en_pin = 0;
        idle("R6 pin off");
        check("R6 off live+latch", {6'd0, status[5:4]}, 8'd3);
        en_pin = 1;
        write_en(5'b11000, "R6 clear");
        idle("R6 wipe 2");
        sw_off = 1;
        idle("R6 sw off");
        check("R6 sw off latch", {6'd0, status[5:4]}, 8'd3);
        sw_off = 0;

        // R10 disabled causes
        write_en(5'b10000, "R10 clear, all disabled");
        idle("R10 wipe");
        hs_oc_off = 1; en_pin = 0;
        convert(12'hFFF, "R10 causes present");
        idle("R10 no latch");
        check("R10 no sticky", {5'd0, status[5], status[3], status[1]}, 8'd0);
        hs_oc_off = 0; en_pin = 1;

        // Random traffic near the threshold, R9 throughout
        for (int i = 0; i < 3000; i++) begin
            res_valid = ($urandom % 3) == 0;
            res_data  = {m_thr, 4'h0} + 12'($urandom % 48) - 12'd16;
            if (($urandom % 10) == 0) hs_oc_off = ~hs_oc_off;
            if (($urandom % 25) == 0) en_pin = ~en_pin;
            if (($urandom % 40) == 0) sw_off = ~sw_off;
            en_wr    = ($urandom % 15) == 0;
            en_wdata = 5'($urandom);
            thr_wr   = ($urandom % 60) == 0;
            thr_wdata = 8'($urandom % 250);
            step("R9 random");
        end
        idle("R9 end");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule